// File: doc/BRIEF.md
# Zero-Count and Population-Count Unit

This unit takes one source operand of XLEN bits (32 or 64) and a 3-bit operation select. It returns one of three counts: the number of zero bits above the highest set bit, the number of zero bits below the lowest set bit, or the number of set bits. When XLEN is 64, it also offers word forms of each count. These forms look only at the low 32 bits of the source.

The count sits in the low bits of the result, and every higher bit is zero. The counting logic is purely combinational. A parameter selects whether a pipeline register follows the result mux; by default the register is present. Instruction decode and register-file writeback belong to the surrounding pipeline.

Top module: `zc_bitcount_unit`

## Requirements
- R1: Operation code 0 returns the number of consecutive zero bits starting at bit XLEN-1 and moving down to the first set bit. A source with bit XLEN-1 set returns 0.
- R2: For an all-zero source, code 0 (leading count) and code 1 (trailing count) both return XLEN.
- R3: Operation code 1 returns the number of consecutive zero bits starting at bit 0 and moving up to the first set bit. A source with bit 0 set returns 0.
- R4: Operation code 2 returns the number of set bits across all XLEN bits.
- R5: When XLEN is 64, code 3 (word leading count) and code 4 (word trailing count) apply the R1 and R3 rules to bits 31:0 only. Each returns 32 when bits 31:0 are all zero.
- R6: When XLEN is 64, code 5 (word population count) returns the number of set bits in bits 31:0.
- R7: For codes 3, 4 and 5, the value of source bits 63:32 has no effect on the result.
- R8: Codes 6 and 7 return zero. When XLEN is 32, codes 3, 4 and 5 also return zero.
- R9: The result uses only its low log2(XLEN)+1 bits. All higher result bits are zero.
- R10: With the output register enabled (the default), a result appears on the clock edge after its inputs are sampled and holds until the next edge. Synchronous reset clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation select |
| src_i | input | XLEN | Source operand |
| res_o | output | XLEN | Zero-extended count |

## Verification
Every count has a latency of one clock. The bench drives an operation and a source on a falling edge, and the rising edge that follows captures the result. The bench then samples the result on the next falling edge, which avoids any race at the capture edge. To check the hold behaviour, one task changes the inputs and reads the output again before the next rising edge; the output must still show the previous count at that point. Assertions compare the output against the inputs from the previous cycle, and they stay disabled until one full cycle after reset has passed.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic [2:0] {
    ZC_LEAD      = 3'd0,
    ZC_TRAIL     = 3'd1,
    ZC_POP       = 3'd2,
    ZC_LEAD_WORD = 3'd3,
    ZC_TRAIL_WORD= 3'd4,
    ZC_POP_WORD  = 3'd5
  } zc_op_e;
  localparam int unsigned ZC_WORD_BITS = 32;
endpackage

// File: rtl/zc_lead_count.sv
// Number of zero bits above the most significant set bit of a W-bit vector.
module zc_lead_count #(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    logic hit;
    hit   = 1'b0;
    cnt_o = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && vec_i[i]) begin
        cnt_o = CW'(W - 1 - i);
        hit   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/zc_pop_count.sv
// Number of set bits in a W-bit vector.
module zc_pop_count #(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/zc_bitcount_unit.sv
module zc_bitcount_unit
  import zc_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned RW  = $clog2(XLEN) + 1;
  localparam int unsigned WB  = ZC_WORD_BITS;
  localparam int unsigned WRW = $clog2(WB) + 1;

  logic [XLEN-1:0] src_rev;
  logic [RW-1:0]   lead_cnt, trail_cnt, pop_cnt;
  logic [WRW-1:0]  lead_w_cnt, trail_w_cnt, pop_w_cnt;
  logic            word_ok;
  logic [RW-1:0]   cnt_sel;
  logic [XLEN-1:0] res_next;

  // Trailing count reuses the leading counter on a mirrored operand.
  for (genvar g = 0; g < XLEN; g++) begin : g_mirror
    assign src_rev[g] = src_i[XLEN-1-g];
  end

  zc_lead_count #(.W(XLEN)) u_lead  (.vec_i(src_i),   .cnt_o(lead_cnt));
  zc_lead_count #(.W(XLEN)) u_trail (.vec_i(src_rev), .cnt_o(trail_cnt));
  zc_pop_count  #(.W(XLEN)) u_pop   (.vec_i(src_i),   .cnt_o(pop_cnt));

  if (XLEN == 64) begin : g_word
    logic [WB-1:0] lo_word, lo_rev;
    assign lo_word = src_i[WB-1:0];
    for (genvar g = 0; g < WB; g++) begin : g_wmirror
      assign lo_rev[g] = lo_word[WB-1-g];
    end
    zc_lead_count #(.W(WB)) u_lead_w  (.vec_i(lo_word), .cnt_o(lead_w_cnt));
    zc_lead_count #(.W(WB)) u_trail_w (.vec_i(lo_rev),  .cnt_o(trail_w_cnt));
    zc_pop_count  #(.W(WB)) u_pop_w   (.vec_i(lo_word), .cnt_o(pop_w_cnt));
    assign word_ok = 1'b1;
  end else begin : g_noword
    assign lead_w_cnt  = '0;
    assign trail_w_cnt = '0;
    assign pop_w_cnt   = '0;
    assign word_ok     = 1'b0;
  end

  always_comb begin
    cnt_sel = '0;
    case (zc_op_e'(op_i))
      ZC_LEAD:       cnt_sel = lead_cnt;
      ZC_TRAIL:      cnt_sel = trail_cnt;
      ZC_POP:        cnt_sel = pop_cnt;
      ZC_LEAD_WORD:  if (word_ok) cnt_sel = RW'(lead_w_cnt);
      ZC_TRAIL_WORD: if (word_ok) cnt_sel = RW'(trail_w_cnt);
      ZC_POP_WORD:   if (word_ok) cnt_sel = RW'(pop_w_cnt);
      default:       cnt_sel = '0;
    endcase
    res_next = XLEN'(cnt_sel);
  end

  if (REG_OUT) begin : g_reg
    logic [XLEN-1:0] res_q;
    logic            live_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        res_q  <= '0;
        live_q <= 1'b0;
      end else begin
        res_q  <= res_next;
        live_q <= 1'b1;
      end
    end
    assign res_o = res_q;

    AST_LEAD_ALLZERO: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(op_i) == 3'd0 && $past(src_i) == '0) |-> res_o == XLEN'(XLEN)); // R2
    AST_LEAD_TOPSET: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(op_i) == 3'd0 && $past(src_i[XLEN-1])) |-> res_o == '0); // R1
    AST_TRAIL_LSBSET: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(op_i) == 3'd1 && $past(src_i[0])) |-> res_o == '0); // R3
    AST_POP_ALLONES: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(op_i) == 3'd2 && $past(&src_i)) |-> res_o == XLEN'(XLEN)); // R4
    AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
      (live_q && $past(op_i) > 3'd5) |-> res_o == '0); // R8
    AST_RES_NARROW: assert property (@(posedge clk) disable iff (rst)
      res_o[XLEN-1:RW] == '0); // R9
    if (XLEN == 64) begin : g_wchk
      AST_WORD_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_i) == 3'd3 && $past(src_i[31:0]) == 32'd0) |-> res_o == XLEN'(32)); // R5
    end
  end else begin : g_comb
    assign res_o = res_next;
  end
endmodule

// File: tb/zc_bitcount_unit_bench.sv
module zc_bitcount_unit_bench;
  localparam int unsigned XLEN = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic [2:0]      op_i;
  logic [XLEN-1:0] src_i;
  logic [XLEN-1:0] res_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  zc_bitcount_unit #(.XLEN(XLEN)) u_zc_bitcount_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .src_i(src_i), .res_o(res_o)
  );

  function automatic logic [XLEN-1:0] model(input logic [2:0] op, input logic [XLEN-1:0] s);
    int n;
    int w;
    logic [XLEN-1:0] v;
    w = (op >= 3 && op <= 5) ? 32 : XLEN;
    v = (w == 32) ? {32'd0, s[31:0]} : s;
    n = 0;
    case (op)
      3'd0, 3'd3: begin n = w; for (int i = w - 1; i >= 0; i--) if (v[i]) begin n = w - 1 - i; break; end end
      3'd1, 3'd4: begin n = w; for (int i = 0; i < w; i++) if (v[i]) begin n = i; break; end end
      3'd2, 3'd5: for (int i = 0; i < w; i++) n += int'(v[i]);
      default: n = 0;
    endcase
    return XLEN'(n);
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] op, input logic [XLEN-1:0] s);
    @(negedge clk);
    op_i = op; src_i = s;
    @(negedge clk);
    check(req, res_o, model(op, s));
    check("R9", {57'd0, res_o[XLEN-1:7]}, '0);
  endtask

  task automatic t_reset;
    rst = 1'b1; op_i = 3'd2; src_i = '1;
    repeat (2) @(negedge clk);
    check("R10 reset", res_o, '0);
    rst = 1'b0;
  endtask

  task automatic t_lead;
    run_op("R1", 3'd0, 64'h8000_0000_0000_0000);
    run_op("R1", 3'd0, 64'h0000_0000_0001_0000);
    run_op("R1", 3'd0, 64'h0000_0000_0000_0001);
    run_op("R2", 3'd0, 64'd0);
    check("R2 lead value", res_o, 64'd64);
  endtask

  task automatic t_trail;
    run_op("R3", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R3", 3'd1, 64'h8000_0000_0000_0000);
    run_op("R3", 3'd1, 64'h0000_0100_0000_0000);
    run_op("R2", 3'd1, 64'd0);
    check("R2 trail value", res_o, 64'd64);
  endtask

  task automatic t_pop;
    run_op("R4", 3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R4", 3'd2, 64'hA5A5_0000_0F0F_8001);
    run_op("R4", 3'd2, 64'd0);
  endtask

  task automatic t_word;
    run_op("R5", 3'd3, 64'hFFFF_FFFF_0000_0000);
    check("R5 lead word zero", res_o, 64'd32);
    run_op("R5", 3'd3, 64'h0000_0000_0000_8000);
    run_op("R5", 3'd4, 64'h1234_5678_0000_0000);
    check("R5 trail word zero", res_o, 64'd32);
    run_op("R5", 3'd4, 64'h0000_0000_0040_0000);
    run_op("R6", 3'd5, 64'h0000_0000_F0F0_0003);
  endtask

  task automatic t_upper_ignored;
    logic [XLEN-1:0] a;
    for (int op = 3; op <= 5; op++) begin
      run_op("R7", 3'(op), 64'h0000_0000_0010_2040);
      a = res_o;
      run_op("R7", 3'(op), 64'hDEAD_BEEF_0010_2040);
      check("R7 upper bits", res_o, a);
    end
  endtask

  task automatic t_bad_ops;
    run_op("R8", 3'd6, 64'h0000_0001_0000_0000);
    check("R8 code 6", res_o, '0);
    run_op("R8", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 code 7", res_o, '0);
  endtask

  task automatic t_latency;
    run_op("R10", 3'd2, 64'h0000_0000_0000_00FF);
    op_i = 3'd0; src_i = 64'h8000_0000_0000_0000;
    #5;
    check("R10 hold", res_o, 64'd8);
    @(negedge clk);
    check("R10 update", res_o, 64'd0);
  endtask

  initial begin
    t_reset();
    t_lead();
    t_trail();
    t_pop();
    t_word();
    t_upper_ignored();
    t_bad_ops();
    t_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule